// File: doc/BRIEF.md
# PS/2 Keyboard Scan-Code Receiver

This block listens to the two open-collector lines of a PS/2 keyboard (clock and data) and turns each key press into one 8-bit scan code on a parallel bus. A strobe one system clock wide marks each new code. The block only receives and never drives either line. Both lines are pulled high when idle. The keyboard toggles the clock only while it sends a frame, so the receiver never relies on a free-running clock.

Each line passes through a synchroniser and a glitch filter, and the receiver then samples data on each filtered falling clock edge. It checks the start, parity and stop bits of every 11-bit frame. A frame that breaks off is dropped after a timeout. Releasing a key makes the keyboard send the prefix byte F0 (hex) followed by the released key's code. The receiver absorbs both bytes, so a release never shows up as a new key press.

Top module: `ps2_keycode_rx`

## Requirements
- R1: While `rst_n` is low at a rising `clk` edge (synchronous, active-low), the output code clears to 8'h00 and the strobe to 0. The same reset also clears the frame bit counter and the pending-release flag.
- R2: A frame has 11 bits, each sampled on a falling PS/2 clock edge: a start bit of 0, eight data bits with the least significant bit first, an odd parity bit (data bits plus parity hold an odd number of ones), and a stop bit of 1. When a valid frame holds a reportable byte, that byte appears on `code_o` with `code_vld_o` high SYNC_STAGES+FILT_LEN+2 `clk` rising edges after the PS/2 clock falls for the stop bit. The edge count starts at the first rising `clk` edge that sees that PS/2 clock low.
- R3: `code_vld_o` is high for exactly one `clk` cycle per reported code and is low at all other times.
- R4: `code_o` holds its value between strobes.
- R5: A received byte of 8'hF0 is never reported. It marks a key release as pending.
- R6: The first valid byte that arrives while a release is pending is discarded and clears the pending flag. Bytes after it are reported again.
- R7: A frame with wrong parity is dropped and produces no output.
- R8: A frame whose stop bit is 0 is dropped and produces no output.
- R9: A falling edge with data high while the receiver is idle does not start a frame.
- R10: If no falling PS/2 clock edge arrives for TIMEOUT_CYC `clk` cycles during a frame, the partial frame is dropped. The receiver returns to idle, and the next full frame decodes correctly.
- R11: A pulse on either PS/2 line that lasts fewer than FILT_LEN `clk` cycles is ignored.
- R12: Reset clears a pending release, so the first byte received after reset is reported.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ps2_clk_i | input | 1 | PS/2 clock line, asynchronous, high when idle |
| ps2_dat_i | input | 1 | PS/2 data line, asynchronous, high when idle |
| code_o | output | 8 | Last reported make code |
| code_vld_o | output | 1 | One-cycle strobe marking a new code |

## Verification
The only timed result is the strobe. It is due SYNC_STAGES+FILT_LEN+2 = 8 `clk` rising edges after the bench drives the stop bit's falling PS/2 clock edge, and no sooner or later. The bench records the cycle count at which it pulls the PS/2 clock low for a stop bit. It queues the expected strobe at that count plus 8. On every falling `clk` edge it compares `code_vld_o` and `code_o` with the queue and with the last expected code. Dropped, released and filtered frames queue nothing, so any strobe from them shows up as a miscompare on that cycle.

// File: rtl/ps2rx_pkg.sv
// Package ps2rx_pkg
// Shared constants and types for the PS/2 scan-code receiver.
// Assumes a keyboard that sends 8-bit scan codes with a one-byte release prefix.
package ps2rx_pkg;
    localparam int          SCAN_BITS   = 8;
    localparam int          FRAME_BITS  = SCAN_BITS + 3;
    typedef logic [SCAN_BITS-1:0] scan_t;
    localparam scan_t       RELEASE_PFX = 8'hF0;
endpackage

// File: rtl/ps2_line_filter.sv
// Module ps2_line_filter
// Brings one asynchronous PS/2 line into the clk domain and debounces it.
// The filtered level changes only after FILT_LEN equal synchronised samples in a row.
// Assumes the line idles high. SYNC_STAGES >= 2 and FILT_LEN >= 2.
module ps2_line_filter #(
    parameter int SYNC_STAGES = 2,
    parameter int FILT_LEN    = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_i,
    output logic level_o
);
    logic [SYNC_STAGES-1:0] sync_q;
    logic                   stage;
    logic [FILT_LEN-1:0]    window;

    // synchroniser chain, reset to the idle-high level
    always_ff @(posedge clk) begin
        if (!rst_n) sync_q <= '1;
        else        sync_q <= {sync_q[SYNC_STAGES-2:0], line_i};
    end

    assign stage = sync_q[SYNC_STAGES-1];

    generate
        if (FILT_LEN == 2) begin : g_short
            logic hist_q;
            // one-deep sample history
            always_ff @(posedge clk) begin
                if (!rst_n) hist_q <= 1'b1;
                else        hist_q <= stage;
            end
            assign window = {hist_q, stage};
        end else begin : g_long
            logic [FILT_LEN-2:0] hist_q;
            // multi-deep sample history
            always_ff @(posedge clk) begin
                if (!rst_n) hist_q <= '1;
                else        hist_q <= {hist_q[FILT_LEN-3:0], stage};
            end
            assign window = {hist_q, stage};
        end
    endgenerate

    // level follows the input only once the whole window agrees
    always_ff @(posedge clk) begin
        if (!rst_n)          level_o <= 1'b1;
        else if (&window)    level_o <= 1'b1;
        else if (~|window)   level_o <= 1'b0;
    end
endmodule

// File: rtl/ps2_frame_rx.sv
// Module ps2_frame_rx
// Assembles 11-bit PS/2 frames from the filtered clock and data levels.
// Checks start, parity and stop, and pulses byte_vld_o for each good byte.
// A frame that stalls for TIMEOUT_CYC cycles is abandoned.
// Assumes inputs are already synchronous to clk.
module ps2_frame_rx
    import ps2rx_pkg::*;
#(
    parameter int TIMEOUT_CYC = 100000,
    localparam int CNT_W = $clog2(FRAME_BITS),
    localparam int TMO_W = $clog2(TIMEOUT_CYC)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             kclk_lvl_i,
    input  logic             kdat_lvl_i,
    output scan_t            byte_o,
    output logic             byte_vld_o,
    output logic [CNT_W-1:0] bit_cnt_o,
    output logic [TMO_W-1:0] tmo_cnt_o
);
    localparam logic [CNT_W-1:0] LAST_DATA = CNT_W'(SCAN_BITS);
    localparam logic [CNT_W-1:0] PAR_POS   = CNT_W'(SCAN_BITS + 1);
    localparam logic [TMO_W-1:0] TMO_LAST  = TMO_W'(TIMEOUT_CYC - 1);

    logic             kclk_prev_q;
    logic             fall;
    logic [CNT_W-1:0] cnt_q;
    logic [TMO_W-1:0] tmo_q;
    scan_t            shift_q;
    logic             par_q;

    // previous clock level for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) kclk_prev_q <= 1'b1;
        else        kclk_prev_q <= kclk_lvl_i;
    end

    assign fall = kclk_prev_q & ~kclk_lvl_i;

    // bit counter, shift register, frame checks and stall timeout
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q      <= '0;
            tmo_q      <= '0;
            shift_q    <= '0;
            par_q      <= 1'b0;
            byte_o     <= '0;
            byte_vld_o <= 1'b0;
        end else begin
            byte_vld_o <= 1'b0;
            if (fall) begin
                tmo_q <= '0;
                if (cnt_q == '0) begin
                    if (!kdat_lvl_i) cnt_q <= CNT_W'(1);
                end else if (cnt_q <= LAST_DATA) begin
                    shift_q <= {kdat_lvl_i, shift_q[SCAN_BITS-1:1]};
                    cnt_q   <= cnt_q + 1'b1;
                end else if (cnt_q == PAR_POS) begin
                    par_q <= kdat_lvl_i;
                    cnt_q <= cnt_q + 1'b1;
                end else begin
                    cnt_q <= '0;
                    if (kdat_lvl_i && (^{shift_q, par_q})) begin
                        byte_o     <= shift_q;
                        byte_vld_o <= 1'b1;
                    end
                end
            end else if (cnt_q == '0) begin
                tmo_q <= '0;
            end else if (tmo_q == TMO_LAST) begin
                tmo_q <= '0;
                cnt_q <= '0;
            end else begin
                tmo_q <= tmo_q + 1'b1;
            end
        end
    end

    assign bit_cnt_o = cnt_q;
    assign tmo_cnt_o = tmo_q;
endmodule

// File: rtl/ps2_release_filter.sv
// Module ps2_release_filter
// Removes key-release sequences from the byte stream.
// An F0 prefix sets a pending flag, and the byte that follows is dropped.
// Every other byte is registered on code_o with a one-cycle strobe.
// Assumes byte_vld_i pulses are at least one cycle apart.
module ps2_release_filter
    import ps2rx_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  scan_t byte_i,
    input  logic  byte_vld_i,
    output scan_t code_o,
    output logic  code_vld_o,
    output logic  pend_o
);
    // release tracking and output register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_o     <= 1'b0;
            code_o     <= '0;
            code_vld_o <= 1'b0;
        end else begin
            code_vld_o <= 1'b0;
            if (byte_vld_i) begin
                if (byte_i == RELEASE_PFX) begin
                    pend_o <= 1'b1;
                end else if (pend_o) begin
                    pend_o <= 1'b0;
                end else begin
                    code_o     <= byte_i;
                    code_vld_o <= 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/ps2_keycode_rx.sv
// Module ps2_keycode_rx
// Top of the PS/2 keyboard receiver: line filters, frame receiver and release filter.
// It only receives and never drives the PS/2 lines.
// Assumes clk is much faster than the PS/2 clock (10-17 kHz).
module ps2_keycode_rx
    import ps2rx_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int FILT_LEN    = 4,
    parameter int TIMEOUT_CYC = 100000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ps2_clk_i,
    input  logic       ps2_dat_i,
    output logic [7:0] code_o,
    output logic       code_vld_o
);
    localparam int CNT_W = $clog2(FRAME_BITS);
    localparam int TMO_W = $clog2(TIMEOUT_CYC);

    logic [1:0]       raw;
    logic [1:0]       lvl;
    scan_t            rx_byte;
    logic             rx_vld;
    logic [CNT_W-1:0] bit_cnt;
    logic [TMO_W-1:0] tmo_cnt;
    logic             pend;

    assign raw = {ps2_dat_i, ps2_clk_i};

    generate
        for (genvar gi = 0; gi < 2; gi++) begin : g_line
            ps2_line_filter #(
                .SYNC_STAGES(SYNC_STAGES),
                .FILT_LEN   (FILT_LEN)
            ) u_flt (
                .clk    (clk),
                .rst_n  (rst_n),
                .line_i (raw[gi]),
                .level_o(lvl[gi])
            );
        end
    endgenerate

    ps2_frame_rx #(
        .TIMEOUT_CYC(TIMEOUT_CYC)
    ) u_frame (
        .clk       (clk),
        .rst_n     (rst_n),
        .kclk_lvl_i(lvl[0]),
        .kdat_lvl_i(lvl[1]),
        .byte_o    (rx_byte),
        .byte_vld_o(rx_vld),
        .bit_cnt_o (bit_cnt),
        .tmo_cnt_o (tmo_cnt)
    );

    ps2_release_filter u_rel (
        .clk       (clk),
        .rst_n     (rst_n),
        .byte_i    (rx_byte),
        .byte_vld_i(rx_vld),
        .code_o    (code_o),
        .code_vld_o(code_vld_o),
        .pend_o    (pend)
    );
endmodule

// File: rtl/ps2_keycode_rx_chk.sv
// Module ps2_keycode_rx_chk
// Property checker bound into ps2_keycode_rx.
module ps2_keycode_rx_chk #(
    parameter int TIMEOUT_CYC = 100000,
    parameter int CNT_W = 4,
    parameter int TMO_W = 17
) (
    input logic             clk,
    input logic             rst_n,
    input logic [7:0]       code_o,
    input logic             code_vld_o,
    input logic [CNT_W-1:0] bit_cnt,
    input logic [TMO_W-1:0] tmo_cnt,
    input logic             rx_vld,
    input logic [7:0]       rx_byte,
    input logic             pend
);
    p_single_strobe_r3: assert property (@(posedge clk) disable iff (!rst_n)
        code_vld_o |=> !code_vld_o);

    p_code_held_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !code_vld_o |-> $stable(code_o));

    p_no_prefix_out_r5: assert property (@(posedge clk) disable iff (!rst_n)
        code_vld_o |-> (code_o != 8'hF0));

    p_pending_swallow_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_vld && pend) |=> !code_vld_o);

    p_prefix_sets_pend_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_vld && rx_byte == 8'hF0) |=> pend);

    p_bit_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
        bit_cnt <= CNT_W'(10));

    p_timeout_bound_r10: assert property (@(posedge clk) disable iff (!rst_n)
        int'(tmo_cnt) < TIMEOUT_CYC);
endmodule

bind ps2_keycode_rx ps2_keycode_rx_chk #(
    .TIMEOUT_CYC(TIMEOUT_CYC),
    .CNT_W      (CNT_W),
    .TMO_W      (TMO_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .code_o    (code_o),
    .code_vld_o(code_vld_o),
    .bit_cnt   (bit_cnt),
    .tmo_cnt   (tmo_cnt),
    .rx_vld    (rx_vld),
    .rx_byte   (rx_byte),
    .pend      (pend)
);

// File: tb/sim_ps2_keycode_rx.sv
module sim_ps2_keycode_rx;
    localparam int S    = 2;
    localparam int F    = 4;
    localparam int TMO  = 400;
    localparam int H    = 25;
    localparam int LAT  = S + F + 2;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       kc = 1'b1;
    logic       kd = 1'b1;
    logic [7:0] code;
    logic       vld;

    int vectors = 0;
    int fails = 0;
    int cyc = 0;
    bit rst_q = 1'b0;
    bit m_pend = 1'b0;
    logic [7:0] m_code = 8'h00;

    typedef struct { int at; logic [7:0] code; } exp_t;
    exp_t q[$];

    always #10 clk = ~clk;

    ps2_keycode_rx #(.SYNC_STAGES(S), .FILT_LEN(F), .TIMEOUT_CYC(TMO)) u0 (
        .clk(clk), .rst_n(rst_n), .ps2_clk_i(kc), .ps2_dat_i(kd),
        .code_o(code), .code_vld_o(vld)
    );

    always @(posedge clk) begin
        cyc++;
        rst_q = rst_n;
    end

    // per-clock comparison against the reference queue
    always @(negedge clk) begin
        if (!rst_q) begin
            m_code = 8'h00;
            q.delete();
        end else begin
            bit due;
            due = (q.size() > 0) && (q[0].at == cyc);
            if (due) begin
                m_code = q[0].code;
                void'(q.pop_front());
            end
            vectors++;
            if (vld !== due) begin
                fails++;
                $display("FAIL R3 strobe cyc %0d: got %b exp %b", cyc, vld, due);
            end
            vectors++;
            if (code !== m_code) begin
                fails++;
                $display("FAIL R4 code cyc %0d: got %h exp %h", cyc, code, m_code);
            end
            if (vld === 1'b1 && code === 8'hF0) begin
                fails++;
                $display("FAIL R5 prefix reported: got %h exp not F0", code);
            end
        end
    end

    task automatic check(input string tag, input logic [7:0] got, input logic [7:0] exp);
        vectors++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got %h exp %h", tag, got, exp);
        end
    endtask

    function automatic logic [10:0] mk_frame(input logic [7:0] b, input bit bad_par,
                                             input logic stop, input logic start);
        return {stop, (~^b) ^ bad_par, b, start};
    endfunction

    // drive nbits frame bits; glitch_at inserts a 2-cycle clock pulse before that bit
    task automatic send_raw(input logic [10:0] bits, input int nbits, input int glitch_at,
                            input bit push, input logic [7:0] pcode);
        for (int i = 0; i < nbits; i++) begin
            if (i == glitch_at) begin
                repeat (3) @(negedge clk);
                kc = 1'b0;
                repeat (2) @(negedge clk);
                kc = 1'b1;
            end
            repeat (H/2) @(negedge clk);
            kd = bits[i];
            repeat (H/2) @(negedge clk);
            kc = 1'b0;
            if (push && i == nbits - 1) q.push_back('{cyc + LAT, pcode});
            repeat (H) @(negedge clk);
            kc = 1'b1;
        end
        repeat (H) @(negedge clk);
        kd = 1'b1;
    endtask

    // good frame through the reference release model
    task automatic send_key(input logic [7:0] b, input int glitch_at = -1);
        bit rep;
        rep = 1'b0;
        if (b == 8'hF0)  m_pend = 1'b1;
        else if (m_pend) m_pend = 1'b0;
        else             rep = 1'b1;
        send_raw(mk_frame(b, 1'b0, 1'b1, 1'b0), 11, glitch_at, rep, b);
        repeat (3*H) @(negedge clk);
    endtask

    task automatic settle();
        repeat (TMO + 50) @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: got hang exp finish");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        check("R1 code after reset", code, 8'h00);
        check("R1 strobe after reset", {7'b0, vld}, 8'h00);
        rst_n = 1'b1;
        repeat (20) @(negedge clk);

        send_key(8'h1C);
        check("R2 make 1C", code, 8'h1C);
        send_key(8'h32);
        send_key(8'hF0);
        send_key(8'h1C);
        check("R6 release swallowed", code, 8'h32);
        send_key(8'h2D);
        check("R6 pending cleared", code, 8'h2D);

        send_raw(mk_frame(8'h45, 1'b1, 1'b1, 1'b0), 11, -1, 1'b0, 8'h00);
        settle();
        check("R7 bad parity dropped", code, 8'h2D);
        send_key(8'h45);
        check("R7 next frame ok", code, 8'h45);

        send_raw(mk_frame(8'h16, 1'b0, 1'b0, 1'b0), 11, -1, 1'b0, 8'h00);
        settle();
        check("R8 stop 0 dropped", code, 8'h45);

        send_raw(mk_frame(8'h1E, 1'b0, 1'b1, 1'b1), 11, -1, 1'b0, 8'h00);
        settle();
        check("R9 start 1 ignored", code, 8'h45);
        send_key(8'h1E);
        check("R9 next frame ok", code, 8'h1E);

        send_raw(mk_frame(8'h26, 1'b0, 1'b1, 1'b0), 5, -1, 1'b0, 8'h00);
        settle();
        send_key(8'h25);
        check("R10 after stall", code, 8'h25);

        send_key(8'h3D, 4);
        check("R11 glitch filtered", code, 8'h3D);

        send_key(8'hF0);
        @(negedge clk);
        rst_n = 1'b0;
        m_pend = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 code cleared by reset", code, 8'h00);
        send_key(8'h1C);
        check("R12 pending cleared by reset", code, 8'h1C);

        repeat (20) @(negedge clk);
        vectors++;
        if (q.size() != 0) begin
            fails++;
            $display("FAIL R2 missing strobes: got %0d pending exp 0", q.size());
        end
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule